// File: doc/BRIEF.md
# Register-Window SPI Command Engine

This block is a small SPI master that the host drives through eight byte-wide registers. The host loads an opcode, up to three address bytes and one trailing data byte. It then writes a control byte. That write starts one framed transfer: 1, 2, 4 or 5 bytes go out, then 0 to 3 bytes come back. The received bytes appear in three readable registers, and a busy flag in register 0 shows when the transfer has finished.

The serial side runs in SPI mode 0 and sends the most significant bit first. The control byte picks one of two serial clock rates. Both rates are fixed fractions of the system clock, set by parameters. The address bytes sit at descending offsets: the byte at offset 4 goes out first and the byte at offset 2 goes out last.

Top module: `spi_cmd_engine`

## Requirements
- R1: Bit 7 of offset 0 reads 1 from the cycle after a start until the transfer is over. At all other times it reads 0, and the other bits of offset 0 read 0. Chip select (`spi_cs_n`, active low) is low exactly while busy is 1.
- R2: The opcode at offset 1 is always the first byte shifted out.
- R3: Control bits 1:0 select the outgoing bytes, in this order: 0 sends the opcode only; 1 sends the opcode then offset 7; 2 sends the opcode then offsets 4, 3, 2; 3 sends the opcode, offsets 4, 3, 2, then offset 7.
- R4: Control bits 3:2 give the number of bytes read back, from 0 to 3. The bytes are clocked in after the outgoing bytes and stored at offsets 5, 6, 7 in order of arrival. MOSI is 0 during the read phase.
- R5: A control write with upper nibble 0x4 starts a transfer with an SCK period of SLOW_DIV system clocks. Upper nibble 0x5 starts one with a period of FAST_DIV system clocks.
- R6: A control write with any other upper nibble starts nothing. Busy stays 0 and no SCK edge appears.
- R7: A control write while busy is 1 is ignored. The running transfer keeps its length, and no further transfer follows it.
- R8: SCK idles low. MOSI changes only while SCK is low. MISO is sampled on the SCK rising edge, and every byte is sent MSB first.
- R9: Chip select rises one full SCK period after the last falling SCK edge.
- R10: Offsets 1 to 4 read back the values last written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The hardest case to reach from the ports is a control write that arrives while a transfer is already running. A wrong design would restart, stretch or chain frames in that case. The bench does this on purpose: right after some starts it writes a maximum-length fast start. It then checks that the count of SCK edges still matches the first command and that chip select stays high afterwards. Random lengths, rates and slave response patterns cover every pairing of write and read lengths.

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine #(
  parameter int SLOW_DIV = 4,
  parameter int FAST_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       spi_sck,
  output logic       spi_cs_n,
  output logic       spi_mosi,
  input  logic       spi_miso
);

  localparam int MAXDIV = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
  localparam int CW = $clog2(MAXDIV) + 1;
  localparam logic [CW-1:0] SLOW_HALF = CW'(SLOW_DIV / 2 - 1);
  localparam logic [CW-1:0] FAST_HALF = CW'(FAST_DIV / 2 - 1);
  localparam logic [CW-1:0] SLOW_FULL = CW'(SLOW_DIV - 1);
  localparam logic [CW-1:0] FAST_FULL = CW'(FAST_DIV - 1);

  typedef enum logic [1:0] {IDLE, XFER, TAIL} st_t;
  st_t st;

  logic [7:0] op_q, a2_q, a3_q, a4_q, d7_q, rx0_q, rx1_q, rx2_q;
  logic [39:0] tx_sh;
  logic [6:0] rx_sh;
  logic [5:0] bit_cnt, last_bit, tx_bits;
  logic [CW-1:0] div_cnt;
  logic fast_q;

  logic busy;
  assign busy     = (st != IDLE);
  assign spi_cs_n = ~busy;
  assign spi_mosi = (st == XFER) ? tx_sh[39] : 1'b0;

  logic start;
  assign start = reg_we && (reg_addr == 3'd0) && !busy &&
                 (reg_wdata[7:4] == 4'h4 || reg_wdata[7:4] == 4'h5);

  logic [2:0] ntx;
  logic [39:0] tx_load;
  always_comb begin
    case (reg_wdata[1:0])
      2'd0: begin ntx = 3'd1; tx_load = {op_q, 32'd0}; end
      2'd1: begin ntx = 3'd2; tx_load = {op_q, d7_q, 24'd0}; end
      2'd2: begin ntx = 3'd4; tx_load = {op_q, a4_q, a3_q, a2_q, 8'd0}; end
      default: begin ntx = 3'd5; tx_load = {op_q, a4_q, a3_q, a2_q, d7_q}; end
    endcase
  end

  logic [3:0] nsum;
  logic [2:0] nm1;
  assign nsum = {1'b0, ntx} + {2'b00, reg_wdata[3:2]};
  assign nm1  = 3'(nsum - 4'd1);

  logic [CW-1:0] half_lim, full_lim;
  assign half_lim = fast_q ? FAST_HALF : SLOW_HALF;
  assign full_lim = fast_q ? FAST_FULL : SLOW_FULL;

  logic [5:0] rx_off;
  assign rx_off = bit_cnt - tx_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q <= '0; a2_q <= '0; a3_q <= '0; a4_q <= '0; d7_q <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        3'd1: op_q <= reg_wdata;
        3'd2: a2_q <= reg_wdata;
        3'd3: a3_q <= reg_wdata;
        3'd4: a4_q <= reg_wdata;
        3'd7: d7_q <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; spi_sck <= 1'b0; div_cnt <= '0; bit_cnt <= '0;
      last_bit <= '0; tx_bits <= '0; tx_sh <= '0; rx_sh <= '0; fast_q <= 1'b0;
      rx0_q <= '0; rx1_q <= '0; rx2_q <= '0;
    end else begin
      case (st)
        IDLE: if (start) begin
          st       <= XFER;
          spi_sck  <= 1'b0;
          div_cnt  <= '0;
          bit_cnt  <= '0;
          tx_sh    <= tx_load;
          tx_bits  <= {ntx, 3'b000};
          last_bit <= {nm1, 3'b111};
          fast_q   <= reg_wdata[4];
        end
        XFER: if (div_cnt == half_lim) begin
          div_cnt <= '0;
          spi_sck <= ~spi_sck;
          if (!spi_sck) begin
            if (bit_cnt >= tx_bits) begin
              if (bit_cnt[2:0] == 3'd7) begin
                case (rx_off[4:3])
                  2'd0: rx0_q <= {rx_sh, spi_miso};
                  2'd1: rx1_q <= {rx_sh, spi_miso};
                  default: rx2_q <= {rx_sh, spi_miso};
                endcase
              end else begin
                rx_sh <= {rx_sh[5:0], spi_miso};
              end
            end
          end else if (bit_cnt == last_bit) begin
            st <= TAIL;
          end else begin
            bit_cnt <= bit_cnt + 6'd1;
            tx_sh   <= {tx_sh[38:0], 1'b0};
          end
        end else begin
          div_cnt <= div_cnt + 1'b1;
        end
        TAIL: if (div_cnt == full_lim) begin
          st <= IDLE; div_cnt <= '0;
        end else begin
          div_cnt <= div_cnt + 1'b1;
        end
        default: st <= IDLE;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      3'd0: reg_rdata = {busy, 7'd0};
      3'd1: reg_rdata = op_q;
      3'd2: reg_rdata = a2_q;
      3'd3: reg_rdata = a3_q;
      3'd4: reg_rdata = a4_q;
      3'd5: reg_rdata = rx0_q;
      3'd6: reg_rdata = rx1_q;
      default: reg_rdata = rx2_q;
    endcase
  end

  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck); // R8
  AST_MOSI_STABLE_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_sck) |-> $stable(spi_mosi)); // R8
  AST_END_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> !spi_sck && $past(!spi_sck)); // R9
  AST_BUSY_WRITE_KEEPS_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_we && reg_addr == 3'd0) |=> $stable(fast_q) && $stable(last_bit)); // R7
  AST_BAD_NIBBLE_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && reg_we && reg_addr == 3'd0 && reg_wdata[7:5] != 3'b010) |=> spi_cs_n); // R6
  AST_BIT_WITHIN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> bit_cnt <= last_bit); // R3

endmodule

// File: tb/spi_cmd_engine_tb_top.sv
`timescale 1ns/1ps
module spi_cmd_engine_tb_top;
  localparam int SLOW = 4;
  localparam int FAST = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic spi_sck, spi_cs_n, spi_mosi, spi_miso;

  always #4 clk = ~clk;

  spi_cmd_engine #(.SLOW_DIV(SLOW), .FAST_DIV(FAST)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sck(spi_sck),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  int checks = 0, failures = 0;
  int rcnt = 0, glitches = 0;
  logic [63:0] resp = '0, mcap = '0;
  time t_r0, t_r1, t_fall, t_rise;

  assign spi_miso = (rcnt < 64) ? resp[63 - rcnt] : 1'b0;

  always @(posedge spi_sck) begin
    if (rcnt == 0) t_r0 = $time;
    if (rcnt == 1) t_r1 = $time;
    if (rcnt < 64) mcap[63 - rcnt] = spi_mosi;
    rcnt = rcnt + 1;
  end
  always @(negedge spi_sck) t_fall = $time;
  always @(posedge spi_cs_n) t_rise = $time;
  always @(spi_mosi) if (spi_sck === 1'b1) glitches = glitches + 1;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  function automatic logic [39:0] tx_vec(input logic [1:0] code, input logic [7:0] op,
      input logic [7:0] a2, input logic [7:0] a3, input logic [7:0] a4, input logic [7:0] d7);
    case (code)
      2'd0: return {op, 32'd0};
      2'd1: return {op, d7, 24'd0};
      2'd2: return {op, a4, a3, a2, 8'd0};
      default: return {op, a4, a3, a2, d7};
    endcase
  endfunction

  function automatic int n_out(input logic [1:0] code);
    case (code) 2'd0: return 1; 2'd1: return 2; 2'd2: return 4; default: return 5; endcase
  endfunction

  task automatic run(input logic [1:0] code, input logic [1:0] nrx, input bit fast,
      input logic [7:0] op, input logic [7:0] a2, input logic [7:0] a3,
      input logic [7:0] a4, input logic [7:0] d7, input logic [63:0] r, input bit inject);
    logic [7:0] v;
    int nb, div, wait_n;
    wr(3'd1, op); wr(3'd2, a2); wr(3'd3, a3); wr(3'd4, a4); wr(3'd7, d7);
    resp = r; mcap = '0; rcnt = 0;
    nb = n_out(code) + int'(nrx);
    div = fast ? FAST : SLOW;
    wr(3'd0, {3'b010, fast, nrx, code});
    rd(3'd0, v);
    check(v == 8'h80 && !spi_cs_n, "R1 busy during transfer", {56'd0, v}, 64'h80);
    if (inject) wr(3'd0, 8'h5F);
    wait_n = 0;
    while (!spi_cs_n && wait_n < 2000) begin @(posedge clk); wait_n++; end
    #1;
    check(rcnt == 8 * nb, inject ? "R7 length kept after busy write" : "R3 bit count",
          64'(rcnt), 64'(8 * nb));
    check(mcap == {tx_vec(code, op, a2, a3, a4, d7), 24'd0}, "R2 R3 R4 mosi stream",
          mcap, {tx_vec(code, op, a2, a3, a4, d7), 24'd0});
    for (int j = 0; j < 3; j++) begin
      if (j < int'(nrx)) begin
        rd(3'(5 + j), v);
        check(v == r[63 - 8 * (n_out(code) + j) -: 8], "R4 read byte", {56'd0, v},
              {56'd0, r[63 - 8 * (n_out(code) + j) -: 8]});
      end
    end
    check((t_r1 - t_r0) == time'(div * 8), "R5 sck period", 64'(t_r1 - t_r0), 64'(div * 8));
    check((t_rise - t_fall) == time'(div * 8), "R9 cs release gap", 64'(t_rise - t_fall), 64'(div * 8));
    rd(3'd0, v);
    check(v == 8'h00, "R1 busy cleared", {56'd0, v}, 64'h0);
    if (inject) begin
      repeat (10) @(posedge clk);
      #1 check(spi_cs_n && rcnt == 8 * nb, "R7 no chained transfer", 64'(rcnt), 64'(8 * nb));
    end
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'h5A17));
    repeat (3) @(posedge clk);
    #1;
    check(spi_cs_n && !spi_sck, "R8 idle lines in reset", {62'd0, spi_cs_n, spi_sck}, 64'h2);
    rst_n = 1'b1;
    rd(3'd0, v);
    check(v == 8'h00, "R1 reset status", {56'd0, v}, 64'h0);

    wr(3'd1, 8'hA5); wr(3'd2, 8'h12); wr(3'd3, 8'h34); wr(3'd4, 8'h56);
    rd(3'd1, v); check(v == 8'hA5, "R10 offset1", {56'd0, v}, 64'hA5);
    rd(3'd2, v); check(v == 8'h12, "R10 offset2", {56'd0, v}, 64'h12);
    rd(3'd3, v); check(v == 8'h34, "R10 offset3", {56'd0, v}, 64'h34);
    rd(3'd4, v); check(v == 8'h56, "R10 offset4", {56'd0, v}, 64'h56);

    rcnt = 0;
    wr(3'd0, 8'h35);
    wr(3'd0, 8'h6F);
    wr(3'd0, 8'hC5);
    repeat (20) @(posedge clk);
    rd(3'd0, v);
    check(v == 8'h00 && rcnt == 0, "R6 bad nibble ignored", 64'(rcnt), 64'h0);

    run(2'd0, 2'd0, 1'b0, 8'h9F, 8'h00, 8'h00, 8'h00, 8'h00, 64'h0, 1'b0);
    run(2'd3, 2'd3, 1'b1, 8'h03, 8'h01, 8'h02, 8'h03, 8'hEE, 64'hFEDC_BA98_7654_3210, 1'b0);
    run(2'd1, 2'd3, 1'b0, 8'h05, 8'h00, 8'h00, 8'h00, 8'h81, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    run(2'd2, 2'd1, 1'b0, 8'h0B, 8'hAA, 8'hBB, 8'hCC, 8'h00, 64'h0123_4567_89AB_CDEF, 1'b1);
    run(2'd0, 2'd2, 1'b1, 8'h90, 8'h00, 8'h00, 8'h00, 8'h00, 64'hA5A5_5A5A_C3C3_3C3C, 1'b1);

    for (int i = 0; i < 40; i++) begin
      run(2'($urandom), 2'($urandom), 1'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
          8'($urandom), 8'($urandom), {$urandom, $urandom}, (i % 7) == 3);
    end

    check(glitches == 0, "R8 mosi stable while sck high", 64'(glitches), 64'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule